// File: doc/BRIEF.md
# CAN Receive Error Counter

This block keeps the receive error count of a CAN node and moves it up or down according to the fault-confinement rules. Frame decoding logic outside the block sends it single-cycle event pulses. The events are: a plain receive error, a bit error while the node sends an active error flag, a dominant level as the first bit after an error flag, each dominant bit seen after an error flag, each recessive bit, and a successful reception that includes the sent acknowledge. Most errors cost 1. The serious ones cost 8. A successful reception lowers the count by one. From the error-passive region it instead drops the count straight to 119.

After an error flag, a run of dominant bits is tolerated up to a limit. The limit is 14 bits when the flag was active and 8 when it was passive. The bit that reaches the limit costs 8, and so does every eighth dominant bit after it. A recessive bit ends the run. The block has three outputs: the count itself, a warning level with a one-cycle interrupt on each upward crossing of 96, and an error-passive level.

Top module: `rx_err_count`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the count to 0, sets warn, warn_irq and err_passive low, and empties the dominant-run tracker.
- R2: An ev_rx_err pulse on its own raises the count by 1 at the next clock edge.
- R3: An ev_flag_bit_err pulse raises the count by 8. If ev_rx_err arrives in the same cycle, its +1 is dropped.
- R4: An ev_first_dom pulse raises the count by 8.
- R5: With flag_act = 1 (the flag was active), the 14th consecutive ev_dom_bit pulse adds 8, and so does every 8th pulse after it (22nd, 30th, ...).
- R6: With flag_act = 0 (the flag was passive), the 8th consecutive ev_dom_bit pulse adds 8, and so does every 8th pulse after it (16th, 24th, ...).
- R7: An ev_rec_bit pulse restarts the dominant-run count from zero. If it coincides with ev_dom_bit, the dominant bit is not counted.
- R8: An ev_rx_ok pulse lowers a count in the range 1 to 127 by 1 and leaves a count of 0 unchanged.
- R9: An ev_rx_ok pulse with the count above 127 sets the count to 119.
- R10: Increments that arrive in the same cycle are added together. Any increment overrides a coincident ev_rx_ok.
- R11: The count saturates at 255 and never wraps.
- R12: warn is high exactly while the count is 96 or more. warn_irq is high for one cycle, in the cycle warn rises, and only then.
- R13: err_passive is high exactly while the count is above 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_rx_err | input | 1 | Plain receive error pulse |
| ev_flag_bit_err | input | 1 | Bit error while sending an active error flag |
| ev_first_dom | input | 1 | Dominant first bit after an error flag |
| ev_dom_bit | input | 1 | One dominant bit seen after an error flag |
| ev_rec_bit | input | 1 | One recessive bit seen, ends the dominant run |
| flag_act | input | 1 | 1 when the preceding error flag was active, 0 when passive |
| ev_rx_ok | input | 1 | Successful reception including the sent acknowledge |
| err_count | output | CNT_W | Receive error count |
| warn | output | 1 | Count at or above the warning limit |
| warn_irq | output | 1 | One-cycle pulse on an upward crossing of the warning limit |
| err_passive | output | 1 | Count above 127 |

## Verification
The checker watches several rules on every cycle:
- the fixed step sizes for isolated events;
- the decrement and the jump to 119 on success;
- the priority of an increment over success;
- saturation at 255;
- the level behaviour of warn and err_passive;
- the rule that warn_irq appears only with a fresh rise of warn.

The dominant-run tolerance spans many cycles, so it is shown only by the bench's scenarios. These cover run lengths for both flag types, runs broken by a recessive bit, and runs cut short by reset. The complete climb to saturation, the descent through the recovery jump down to zero, and a second interrupt on a renewed climb are also covered only by the scenarios.

// File: rtl/rec_pkg.sv
package rec_pkg;
   // Increment sources gathered in one cycle
   typedef struct packed {
      logic small_err;
      logic flag_bit_err;
      logic first_dom;
      logic run_pen;
   } rec_bump_t;
endpackage

// File: rtl/rec_run_tracker.sv
module rec_run_tracker #(
   parameter int ACT_FIRST = 14,
   parameter int PAS_FIRST = 8,
   parameter int REPEAT    = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic dom_bit,
   input  logic rec_bit,
   input  logic flag_act,
   output logic pen
);
   localparam int FIRST_MAX = (ACT_FIRST > PAS_FIRST) ? ACT_FIRST : PAS_FIRST;
   localparam int RUN_W     = $clog2(FIRST_MAX + 1);
   localparam int REP_W     = $clog2(REPEAT + 1);

   logic [RUN_W-1:0] run_q, run_nx, thr;
   logic [REP_W-1:0] rep_q, rep_nx;
   logic             tail_q;

   generate
      if (ACT_FIRST == PAS_FIRST) begin : g_one_thr
         logic unused_act;
         assign unused_act = flag_act;
         assign thr = RUN_W'(ACT_FIRST);
      end else begin : g_two_thr
         assign thr = flag_act ? RUN_W'(ACT_FIRST) : RUN_W'(PAS_FIRST);
      end
   endgenerate

   assign run_nx = run_q + RUN_W'(1);
   assign rep_nx = rep_q + REP_W'(1);

   always_comb begin
      pen = 1'b0;
      if (dom_bit && !rec_bit) begin
         if (tail_q) pen = (rep_nx == REP_W'(REPEAT));
         else        pen = (run_nx >= thr);
      end
   end

   always_ff @(posedge clk) begin
      if (rst || rec_bit) begin
         run_q  <= '0;
         rep_q  <= '0;
         tail_q <= 1'b0;
      end else if (dom_bit) begin
         if (tail_q) begin
            rep_q <= (rep_nx == REP_W'(REPEAT)) ? '0 : rep_nx;
         end else if (run_nx >= thr) begin
            tail_q <= 1'b1;
            rep_q  <= '0;
            run_q  <= run_nx;
         end else begin
            run_q <= run_nx;
         end
      end
   end
endmodule

// File: rtl/rec_step_calc.sv
module rec_step_calc
   import rec_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int SMALL_STEP   = 1,
   parameter int BIG_STEP     = 8,
   parameter int PASSIVE_ABOVE = 127,
   parameter int RECOVER_VAL  = 119
) (
   input  logic [CNT_W-1:0] cnt,
   input  rec_bump_t        bump,
   input  logic             ok,
   output logic [CNT_W-1:0] nxt
);
   localparam int SUM_W = CNT_W + 3;
   localparam logic [SUM_W-1:0] SMALL_V = SUM_W'(SMALL_STEP);
   localparam logic [SUM_W-1:0] BIG_V   = SUM_W'(BIG_STEP);
   localparam logic [SUM_W-1:0] MAX_S   = SUM_W'((1 << CNT_W) - 1);
   localparam logic [CNT_W-1:0] MAX_V   = CNT_W'((1 << CNT_W) - 1);
   localparam logic [CNT_W-1:0] PASS_V  = CNT_W'(PASSIVE_ABOVE);
   localparam logic [CNT_W-1:0] REC_V   = CNT_W'(RECOVER_VAL);

   logic [SUM_W-1:0] inc, sum;

   always_comb begin
      inc = '0;
      if (bump.flag_bit_err)   inc = inc + BIG_V;
      else if (bump.small_err) inc = inc + SMALL_V;
      if (bump.first_dom)      inc = inc + BIG_V;
      if (bump.run_pen)        inc = inc + BIG_V;
   end

   assign sum = SUM_W'(cnt) + inc;

   always_comb begin
      if (inc != '0)          nxt = (sum > MAX_S) ? MAX_V : sum[CNT_W-1:0];
      else if (!ok)           nxt = cnt;
      else if (cnt > PASS_V)  nxt = REC_V;
      else if (cnt != '0)     nxt = cnt - CNT_W'(1);
      else                    nxt = cnt;
   end
endmodule

// File: rtl/rec_level_flags.sv
module rec_level_flags #(
   parameter int CNT_W    = 8,
   parameter int WARN_LIM = 96
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] nxt,
   output logic             warn,
   output logic             irq
);
   localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
   logic above;
   assign above = (nxt >= WARN_V);

   always_ff @(posedge clk) begin
      if (rst) begin
         warn <= 1'b0;
         irq  <= 1'b0;
      end else begin
         warn <= above;
         irq  <= above && !warn;
      end
   end
endmodule

// File: rtl/rx_err_count.sv
module rx_err_count
   import rec_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int SMALL_STEP    = 1,
   parameter int BIG_STEP      = 8,
   parameter int WARN_LIM      = 96,
   parameter int PASSIVE_ABOVE = 127,
   parameter int RECOVER_VAL   = 119,
   parameter int ACT_FIRST     = 14,
   parameter int PAS_FIRST     = 8,
   parameter int RUN_REPEAT    = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ev_rx_err,
   input  logic             ev_flag_bit_err,
   input  logic             ev_first_dom,
   input  logic             ev_dom_bit,
   input  logic             ev_rec_bit,
   input  logic             flag_act,
   input  logic             ev_rx_ok,
   output logic [CNT_W-1:0] err_count,
   output logic             warn,
   output logic             warn_irq,
   output logic             err_passive
);
   localparam int MAX_CNT = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_ABOVE);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("rx_err_count: CNT_W out of range");
      end
      if (WARN_LIM < 1 || WARN_LIM > MAX_CNT) begin : g_bad_warn
         $error("rx_err_count: WARN_LIM out of range");
      end
      if (PASSIVE_ABOVE >= MAX_CNT || RECOVER_VAL > PASSIVE_ABOVE) begin : g_bad_pass
         $error("rx_err_count: passive or recovery level inconsistent");
      end
      if (SMALL_STEP < 1 || BIG_STEP < 1 || BIG_STEP > MAX_CNT) begin : g_bad_step
         $error("rx_err_count: step sizes out of range");
      end
      if (ACT_FIRST < 1 || PAS_FIRST < 1 || RUN_REPEAT < 1) begin : g_bad_run
         $error("rx_err_count: run limits must be positive");
      end
   endgenerate

   logic             run_pen;
   rec_bump_t        bump;
   logic [CNT_W-1:0] cnt_q, cnt_nx;

   rec_run_tracker #(
      .ACT_FIRST(ACT_FIRST), .PAS_FIRST(PAS_FIRST), .REPEAT(RUN_REPEAT)
   ) u_run (
      .clk(clk), .rst(rst), .dom_bit(ev_dom_bit), .rec_bit(ev_rec_bit),
      .flag_act(flag_act), .pen(run_pen)
   );

   assign bump.small_err    = ev_rx_err;
   assign bump.flag_bit_err = ev_flag_bit_err;
   assign bump.first_dom    = ev_first_dom;
   assign bump.run_pen      = run_pen;

   rec_step_calc #(
      .CNT_W(CNT_W), .SMALL_STEP(SMALL_STEP), .BIG_STEP(BIG_STEP),
      .PASSIVE_ABOVE(PASSIVE_ABOVE), .RECOVER_VAL(RECOVER_VAL)
   ) u_step (
      .cnt(cnt_q), .bump(bump), .ok(ev_rx_ok), .nxt(cnt_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_nx;
   end

   rec_level_flags #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM)) u_flags (
      .clk(clk), .rst(rst), .nxt(cnt_nx), .warn(warn), .irq(warn_irq)
   );

   assign err_count   = cnt_q;
   assign err_passive = (cnt_q > PASS_V);
endmodule

// File: rtl/rx_err_count_chk.sv
module rx_err_count_chk #(
   parameter int CNT_W         = 8,
   parameter int SMALL_STEP    = 1,
   parameter int BIG_STEP      = 8,
   parameter int WARN_LIM      = 96,
   parameter int PASSIVE_ABOVE = 127,
   parameter int RECOVER_VAL   = 119
) (
   input logic             clk,
   input logic             rst,
   input logic             ev_rx_err,
   input logic             ev_flag_bit_err,
   input logic             ev_first_dom,
   input logic             ev_dom_bit,
   input logic             ev_rx_ok,
   input logic [CNT_W-1:0] err_count,
   input logic             warn,
   input logic             warn_irq,
   input logic             err_passive
);
   localparam int MAX_CNT = (1 << CNT_W) - 1;
   logic any_inc;
   assign any_inc = ev_rx_err || ev_flag_bit_err || ev_first_dom;

   // R2: lone plain error adds the small step below saturation
   p_small_step_r2: assert property (@(posedge clk) disable iff (rst)
      (ev_rx_err && !ev_flag_bit_err && !ev_first_dom && !ev_dom_bit &&
       int'(err_count) <= MAX_CNT - SMALL_STEP)
      |=> int'(err_count) == int'($past(err_count)) + SMALL_STEP);

   // R4: lone first-dominant event adds the big step
   p_first_dom_r4: assert property (@(posedge clk) disable iff (rst)
      (ev_first_dom && !ev_rx_err && !ev_flag_bit_err && !ev_dom_bit &&
       int'(err_count) <= MAX_CNT - BIG_STEP)
      |=> int'(err_count) == int'($past(err_count)) + BIG_STEP);

   // R8: success decrements inside 1..PASSIVE_ABOVE
   p_ok_dec_r8: assert property (@(posedge clk) disable iff (rst)
      (ev_rx_ok && !any_inc && !ev_dom_bit && err_count != '0 &&
       int'(err_count) <= PASSIVE_ABOVE)
      |=> int'(err_count) == int'($past(err_count)) - 1);

   // R9: success from the passive region lands on the recovery value
   p_recover_r9: assert property (@(posedge clk) disable iff (rst)
      (ev_rx_ok && !any_inc && !ev_dom_bit && int'(err_count) > PASSIVE_ABOVE)
      |=> int'(err_count) == RECOVER_VAL);

   // R10: any increment beats a coincident success
   p_inc_wins_r10: assert property (@(posedge clk) disable iff (rst)
      (any_inc && ev_rx_ok) |=> err_count >= $past(err_count));

   // R11: no wrap at the top
   p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
      (int'(err_count) == MAX_CNT && !ev_rx_ok) |=> int'(err_count) == MAX_CNT);

   // R12: warn level follows the count, interrupt only on a fresh rise
   p_warn_level_r12: assert property (@(posedge clk) disable iff (rst)
      warn == (int'(err_count) >= WARN_LIM));
   p_irq_edge_r12: assert property (@(posedge clk) disable iff (rst)
      warn_irq |-> (warn && !$past(warn)));

   // R13: passive level follows the count
   p_passive_level_r13: assert property (@(posedge clk) disable iff (rst)
      $changed(err_passive) |-> ($changed(err_count) || $past(rst)));
endmodule

bind rx_err_count rx_err_count_chk #(
   .CNT_W(CNT_W), .SMALL_STEP(SMALL_STEP), .BIG_STEP(BIG_STEP),
   .WARN_LIM(WARN_LIM), .PASSIVE_ABOVE(PASSIVE_ABOVE), .RECOVER_VAL(RECOVER_VAL)
) u_chk (
   .clk(clk), .rst(rst), .ev_rx_err(ev_rx_err), .ev_flag_bit_err(ev_flag_bit_err),
   .ev_first_dom(ev_first_dom), .ev_dom_bit(ev_dom_bit), .ev_rx_ok(ev_rx_ok),
   .err_count(err_count), .warn(warn), .warn_irq(warn_irq), .err_passive(err_passive)
);

// File: tb/sim_rx_err_count.sv
`timescale 1ns/1ps
module sim_rx_err_count;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ev_rx_err = 0, ev_flag_bit_err = 0, ev_first_dom = 0, ev_dom_bit = 0;
   logic ev_rec_bit = 0, flag_act = 0, ev_rx_ok = 0;
   logic [7:0] err_count;
   logic warn, warn_irq, err_passive;

   int n_chk = 0, n_fail = 0;
   int m_cnt = 0, m_run = 0;
   bit m_warn = 0, m_irq = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rx_err_count u0 (
      .clk(clk), .rst(rst), .ev_rx_err(ev_rx_err), .ev_flag_bit_err(ev_flag_bit_err),
      .ev_first_dom(ev_first_dom), .ev_dom_bit(ev_dom_bit), .ev_rec_bit(ev_rec_bit),
      .flag_act(flag_act), .ev_rx_ok(ev_rx_ok), .err_count(err_count), .warn(warn),
      .warn_irq(warn_irq), .err_passive(err_passive)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, int'(err_count), m_cnt);
      chk("R12 warn", int'(warn), int'(m_warn));
      chk("R12 warn_irq", int'(warn_irq), int'(m_irq));
      chk("R13 err_passive", int'(err_passive), int'(m_cnt > 127));
   endtask

   // Expected behaviour derived from the requirements
   task automatic model(input bit rxe, input bit fbe, input bit fd, input bit dom,
                        input bit act, input bit rec, input bit ok);
      int inc = 0;
      int thr;
      if (fbe) inc += 8;          // R3
      else if (rxe) inc += 1;     // R2
      if (fd) inc += 8;           // R4
      if (rec) m_run = 0;         // R7
      else if (dom) begin
         m_run++;
         thr = act ? 14 : 8;      // R5, R6
         if (m_run == thr || (m_run > thr && (m_run - thr) % 8 == 0)) inc += 8;
      end
      if (inc > 0) m_cnt = (m_cnt + inc > 255) ? 255 : m_cnt + inc; // R10, R11
      else if (ok) m_cnt = (m_cnt > 127) ? 119 : (m_cnt > 0 ? m_cnt - 1 : 0); // R8, R9
      m_irq  = (m_cnt >= 96) && !m_warn;
      m_warn = (m_cnt >= 96);
   endtask

   task automatic apply(input bit rxe, input bit fbe, input bit fd, input bit dom,
                        input bit act, input bit rec, input bit ok, input string req);
      ev_rx_err = rxe; ev_flag_bit_err = fbe; ev_first_dom = fd; ev_dom_bit = dom;
      flag_act = act; ev_rec_bit = rec; ev_rx_ok = ok;
      model(rxe, fbe, fd, dom, act, rec, ok);
      @(posedge clk); #1;
      ev_rx_err = 0; ev_flag_bit_err = 0; ev_first_dom = 0; ev_dom_bit = 0;
      ev_rec_bit = 0; ev_rx_ok = 0;
      check_all(req);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      m_cnt = 0; m_run = 0; m_warn = 0; m_irq = 0;
      check_all("R1 reset count");
      rst = 1'b0;
   endtask

   initial begin
      #1;
      do_reset();
      // R2, R11, R12, R13: climb to saturation one error at a time
      for (int i = 0; i < 262; i++) apply(1, 0, 0, 0, 0, 0, 0, "R2 R11 climb");
      // R8, R9: descend by successes through the recovery jump to zero
      for (int i = 0; i < 124; i++) apply(0, 0, 0, 0, 0, 0, 1, "R8 R9 descend");
      // R12: renewed climb fires the interrupt again
      for (int i = 0; i < 100; i++) apply(1, 0, 0, 0, 0, 0, 0, "R12 reclimb");

      do_reset();
      apply(1, 1, 0, 0, 0, 0, 0, "R3 flag bit error suppresses +1");
      apply(0, 1, 0, 0, 0, 0, 0, "R3 flag bit error");
      apply(0, 0, 1, 0, 0, 0, 0, "R4 first dominant");
      apply(1, 1, 1, 0, 0, 0, 1, "R10 sum beats success");
      apply(0, 0, 1, 0, 0, 0, 1, "R10 first dominant beats success");
      apply(1, 0, 0, 0, 0, 0, 1, "R10 small error beats success");
      apply(0, 0, 0, 0, 0, 0, 1, "R8 success");

      do_reset();
      for (int i = 0; i < 38; i++) apply(0, 0, 0, 1, 1, 0, 0, "R5 active run");
      apply(0, 0, 0, 0, 1, 1, 0, "R7 recessive");
      for (int i = 0; i < 13; i++) apply(0, 0, 0, 1, 1, 0, 0, "R7 run restarted");
      apply(0, 0, 0, 1, 1, 1, 0, "R7 recessive beats dominant");
      for (int i = 0; i < 14; i++) apply(0, 0, 0, 1, 1, 0, 0, "R7 R5 fresh run");

      do_reset();
      for (int i = 0; i < 25; i++) apply(0, 0, 0, 1, 0, 0, 0, "R6 passive run");
      for (int i = 0; i < 10; i++) apply(0, 0, 0, 1, 0, 0, 0, "R6 passive tail");
      do_reset();
      for (int i = 0; i < 8; i++) apply(0, 0, 0, 1, 0, 0, 0, "R1 run cleared by reset");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(100000 * 10);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule